// File: doc/BRIEF.md
# Parallel Programming Command Interface

This block is the target-side controller for a byte-wide parallel programming port on a small microcontroller. An external programmer pulses a strobe line. On each rising edge of the strobe the block reads a two-bit action code and a byte-select line. Depending on the action code, the byte on the shared data bus is latched as half of the memory address, as half of the write data, or as a command byte. The command byte is decoded when it is latched.

An operation that changes state starts on the falling edge of an active-low write input. The block then runs the operation against behavioural models of the program flash, the data EEPROM, a fuse byte and a lock byte. While the operation runs, the ready flag stays low. Chip erase sweeps every flash word and every EEPROM byte to all ones. Only after both sweeps does it restore the lock byte, and it never touches the fuses.

Read commands need no write pulse. While the active-low output enable is held, the block drives the selected byte onto the bus through a registered path. At all other times it releases the bus.

Top module: `ppi_prog_ctrl`

## Requirements
- R1: On each rising edge of `strobe_i` while ready, `action_i` = 00 latches an address byte, 01 latches a data byte and 10 latches the command byte, all taken from the bus. Code 11 changes nothing.
- R2: For address and data loads, `bsel_i` = 0 fills the low byte and `bsel_i` = 1 fills the high byte.
- R3: The command codes are 0x80 chip erase, 0x40 write fuses, 0x20 write lock, 0x10 write flash word, 0x11 write EEPROM byte, 0x08 read signature, 0x04 read fuse/lock, 0x02 read flash and 0x03 read EEPROM. A write-type command starts only on a falling edge of `wr_n_i` while ready.
- R4: `rdy_o` is 1 when a command can be accepted and 0 while an operation runs. A write lasts exactly WR_CYCLES clock cycles. A chip erase lasts 2^FLASH_AW + 2^EE_AW + 1 cycles.
- R5: The block drives `data_io` only while `oe_n_i` is low, a read command is active and the block is ready. In every other case the bus is released. A driven value settles within four clock cycles of the address, the byte select or the output enable changing.
- R6: After a chip erase, every flash word reads 0xFFFF and every EEPROM byte reads 0xFF. The lock byte returns to 0xFF only after both memory sweeps have finished. The fuse byte is unchanged.
- R7: Strobe loads and write pulses that arrive while `rdy_o` is 0 are ignored.
- R8: A command byte with no defined code is latched, but a write pulse then starts nothing (`rdy_o` stays 1) and the bus is never driven.
- R9: When reading flash, `bsel_i` = 0 returns the low byte of the word at the latched address and `bsel_i` = 1 returns the high byte. When reading EEPROM, the byte at the latched address is returned. Signature byte n (n = 0..2, chosen by address bits 1:0) is SIGNATURE[8n+7:8n], and index 3 reads 0xFF. For fuse/lock reads, `bsel_i` = 0 returns the fuse byte and 1 returns the lock byte.
- R10: After reset, `rdy_o` = 1, the fuse byte is FUSE_INIT, the lock byte is 0xFF, the address is 0 and the latched command is 0x00 (undefined).
- R11: Write fuses loads the fuse byte with the low data byte. Write lock loads the lock byte with the low data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Load strobe; the rising edge performs the action |
| action_i | input | 2 | Action code sampled on a strobe edge |
| bsel_i | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_n_i | input | 1 | Active-low write pulse; the falling edge starts an operation |
| oe_n_i | input | 1 | Active-low output enable for reads |
| data_io | inout | 8 | Bidirectional data bus |
| rdy_o | output | 1 | 1 ready, 0 busy |

## Verification
On every cycle, the bound checker confirms four behaviours:
- the bus is released one cycle after the output enable rises, and whenever the block is busy;
- the address latch holds still while busy;
- the fuse and lock bytes stay frozen during the erase sweeps;
- the ready flag falls only after a write pulse has fallen.

Other behaviours need the bench's scenarios to show them:
- the exact busy lengths;
- the byte steering of the loads and reads;
- the all-ones result of an erase and the later restoration of the lock byte;
- the signature bytes;
- the fact that loads and second write pulses arriving during busy are lost.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

  localparam int BUS_W  = 8;
  localparam int ADDR_W = 16;

  // strobe action codes
  localparam logic [1:0] ACT_ADDR = 2'b00;
  localparam logic [1:0] ACT_DATA = 2'b01;
  localparam logic [1:0] ACT_CMD  = 2'b10;

  // command byte codes
  localparam logic [7:0] CODE_ERASE  = 8'h80;
  localparam logic [7:0] CODE_WFUSE  = 8'h40;
  localparam logic [7:0] CODE_WLOCK  = 8'h20;
  localparam logic [7:0] CODE_WFLASH = 8'h10;
  localparam logic [7:0] CODE_WEE    = 8'h11;
  localparam logic [7:0] CODE_RSIG   = 8'h08;
  localparam logic [7:0] CODE_RFL    = 8'h04;
  localparam logic [7:0] CODE_RFLASH = 8'h02;
  localparam logic [7:0] CODE_REE    = 8'h03;

  typedef enum logic [3:0] {
    OP_NONE, OP_ERASE, OP_WFUSE, OP_WLOCK, OP_WFLASH, OP_WEE,
    OP_RSIG, OP_RFUSELOCK, OP_RFLASH, OP_REE
  } op_e;

  function automatic op_e decode_cmd(input logic [7:0] code);
    case (code)
      CODE_ERASE:  return OP_ERASE;
      CODE_WFUSE:  return OP_WFUSE;
      CODE_WLOCK:  return OP_WLOCK;
      CODE_WFLASH: return OP_WFLASH;
      CODE_WEE:    return OP_WEE;
      CODE_RSIG:   return OP_RSIG;
      CODE_RFL:    return OP_RFUSELOCK;
      CODE_RFLASH: return OP_RFLASH;
      CODE_REE:    return OP_REE;
      default:     return OP_NONE;
    endcase
  endfunction

  function automatic logic is_write_op(input op_e op);
    return (op == OP_ERASE) || (op == OP_WFUSE) || (op == OP_WLOCK) ||
           (op == OP_WFLASH) || (op == OP_WEE);
  endfunction

  function automatic logic is_read_op(input op_e op);
    return (op == OP_RSIG) || (op == OP_RFUSELOCK) ||
           (op == OP_RFLASH) || (op == OP_REE);
  endfunction

endpackage

// File: rtl/ppi_latch.sv
module ppi_latch
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [1:0]        action,
  input  logic              bsel,
  input  logic              accept,
  input  logic [BUS_W-1:0]  din,
  output logic [ADDR_W-1:0] addr,
  output logic [2*BUS_W-1:0] wdata,
  output op_e               op
);

  logic strobe_q;
  logic load;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign load = strobe & ~strobe_q & accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      wdata <= '1;
      op    <= OP_NONE;
    end else if (load) begin
      case (action)
        ACT_ADDR: begin
          if (bsel) addr[ADDR_W-1:BUS_W] <= din;
          else      addr[BUS_W-1:0]      <= din;
        end
        ACT_DATA: begin
          if (bsel) wdata[2*BUS_W-1:BUS_W] <= din;
          else      wdata[BUS_W-1:0]       <= din;
        end
        ACT_CMD:  op <= decode_cmd(din);
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/ppi_ram.sv
module ppi_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end

endmodule

// File: rtl/ppi_seq.sv
module ppi_seq
  import ppi_pkg::*;
#(
  parameter int FLASH_AW  = 10,
  parameter int EE_AW     = 8,
  parameter int WR_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_n,
  input  op_e                 op,
  input  logic [FLASH_AW-1:0] flash_addr,
  input  logic [EE_AW-1:0]    ee_addr,
  input  logic [2*BUS_W-1:0]  wdata,
  output logic                rdy,
  output logic                erasing,
  output logic                flash_we,
  output logic [FLASH_AW-1:0] flash_wa,
  output logic [2*BUS_W-1:0]  flash_wd,
  output logic                ee_we,
  output logic [EE_AW-1:0]    ee_wa,
  output logic [BUS_W-1:0]    ee_wd,
  output logic                fuse_we,
  output logic                lock_we,
  output logic                lock_set
);

  localparam int FLASH_DEPTH = 1 << FLASH_AW;
  localparam int EE_DEPTH    = 1 << EE_AW;
  localparam int IDX_W       = (FLASH_AW > EE_AW) ? FLASH_AW : EE_AW;
  localparam int CNT_W       = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_WGO, S_WAIT, S_EFL, S_EEE, S_ELK} st_e;

  st_e              state;
  op_e              op_q;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;
  logic             start;

  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b1;
    else     wr_q <= wr_n;
  end

  assign start = (state == S_IDLE) && wr_q && !wr_n && is_write_op(op);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      op_q  <= OP_NONE;
      idx   <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op_q <= op;
          idx  <= '0;
          state <= (op == OP_ERASE) ? S_EFL : S_WGO;
        end
        S_WGO: begin
          cnt   <= CNT_W'(WR_CYCLES - 2);
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        S_EFL: begin
          if (idx == IDX_W'(FLASH_DEPTH - 1)) begin
            idx   <= '0;
            state <= S_EEE;
          end else idx <= idx + 1'b1;
        end
        S_EEE: begin
          if (idx == IDX_W'(EE_DEPTH - 1)) state <= S_ELK;
          else                              idx   <= idx + 1'b1;
        end
        S_ELK:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rdy      = (state == S_IDLE);
  assign erasing  = (state == S_EFL) || (state == S_EEE);

  assign flash_we = (state == S_EFL) || ((state == S_WGO) && (op_q == OP_WFLASH));
  assign flash_wa = (state == S_EFL) ? idx[FLASH_AW-1:0] : flash_addr;
  assign flash_wd = (state == S_EFL) ? '1 : wdata;

  assign ee_we    = (state == S_EEE) || ((state == S_WGO) && (op_q == OP_WEE));
  assign ee_wa    = (state == S_EEE) ? idx[EE_AW-1:0] : ee_addr;
  assign ee_wd    = (state == S_EEE) ? '1 : wdata[BUS_W-1:0];

  assign fuse_we  = (state == S_WGO) && (op_q == OP_WFUSE);
  assign lock_we  = (state == S_WGO) && (op_q == OP_WLOCK);
  assign lock_set = (state == S_ELK);

endmodule

// File: rtl/ppi_prog_ctrl.sv
module ppi_prog_ctrl
  import ppi_pkg::*;
#(
  parameter int          FLASH_AW  = 10,
  parameter int          EE_AW     = 8,
  parameter int          WR_CYCLES = 8,
  parameter logic [7:0]  FUSE_INIT = 8'hD9,
  parameter logic [23:0] SIGNATURE = 24'h05931E
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe_i,
  input  logic [1:0] action_i,
  input  logic       bsel_i,
  input  logic       wr_n_i,
  input  logic       oe_n_i,
  inout  wire  [7:0] data_io,
  output logic       rdy_o
);

  logic [BUS_W-1:0]    din;
  logic [ADDR_W-1:0]   addr;
  logic [2*BUS_W-1:0]  wdata;
  op_e                 op;
  logic                rdy;
  logic                erasing;
  logic                flash_we, ee_we, fuse_we, lock_we, lock_set;
  logic [FLASH_AW-1:0] flash_wa;
  logic [2*BUS_W-1:0]  flash_wd, flash_rd;
  logic [EE_AW-1:0]    ee_wa;
  logic [BUS_W-1:0]    ee_wd, ee_rd;
  logic [BUS_W-1:0]    fuse_q, lock_q;
  logic [BUS_W-1:0]    rd_byte, out_q;
  logic                drv_q;
  logic                unused_addr_hi;

  assign din            = data_io;
  assign unused_addr_hi = ^addr[ADDR_W-1:FLASH_AW];

  ppi_latch u_latch (
    .clk(clk), .rst(rst), .strobe(strobe_i), .action(action_i), .bsel(bsel_i),
    .accept(rdy), .din(din), .addr(addr), .wdata(wdata), .op(op)
  );

  ppi_seq #(.FLASH_AW(FLASH_AW), .EE_AW(EE_AW), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .wr_n(wr_n_i), .op(op),
    .flash_addr(addr[FLASH_AW-1:0]), .ee_addr(addr[EE_AW-1:0]), .wdata(wdata),
    .rdy(rdy), .erasing(erasing),
    .flash_we(flash_we), .flash_wa(flash_wa), .flash_wd(flash_wd),
    .ee_we(ee_we), .ee_wa(ee_wa), .ee_wd(ee_wd),
    .fuse_we(fuse_we), .lock_we(lock_we), .lock_set(lock_set)
  );

  ppi_ram #(.DW(2*BUS_W), .AW(FLASH_AW)) u_flash (
    .clk(clk), .we(flash_we), .wa(flash_wa), .wd(flash_wd),
    .ra(addr[FLASH_AW-1:0]), .rd(flash_rd)
  );

  ppi_ram #(.DW(BUS_W), .AW(EE_AW)) u_eeprom (
    .clk(clk), .we(ee_we), .wa(ee_wa), .wd(ee_wd),
    .ra(addr[EE_AW-1:0]), .rd(ee_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fuse_q <= FUSE_INIT;
      lock_q <= '1;
    end else begin
      if (fuse_we)       fuse_q <= wdata[BUS_W-1:0];
      if (lock_set)      lock_q <= '1;
      else if (lock_we)  lock_q <= wdata[BUS_W-1:0];
    end
  end

  always_comb begin
    case (op)
      OP_RFLASH:    rd_byte = bsel_i ? flash_rd[2*BUS_W-1:BUS_W] : flash_rd[BUS_W-1:0];
      OP_REE:       rd_byte = ee_rd;
      OP_RFUSELOCK: rd_byte = bsel_i ? lock_q : fuse_q;
      OP_RSIG: begin
        case (addr[1:0])
          2'd0:    rd_byte = SIGNATURE[7:0];
          2'd1:    rd_byte = SIGNATURE[15:8];
          2'd2:    rd_byte = SIGNATURE[23:16];
          default: rd_byte = 8'hFF;
        endcase
      end
      default:      rd_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      drv_q <= 1'b0;
    end else begin
      out_q <= rd_byte;
      drv_q <= !oe_n_i && rdy && is_read_op(op);
    end
  end

  assign data_io = drv_q ? out_q : 8'hzz;
  assign rdy_o   = rdy;

endmodule

// File: rtl/ppi_chk.sv
module ppi_chk (
  input logic        clk,
  input logic        rst,
  input logic        oe_n,
  input logic        wr_n,
  input logic        rdy,
  input logic        drv,
  input logic        erasing,
  input logic [15:0] addr,
  input logic [7:0]  fuse,
  input logic [7:0]  lock
);

  assert_bus_release_R5: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !drv);

  assert_busy_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> !drv);

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> $stable(addr));

  assert_fuse_kept_R6: assert property (@(posedge clk) disable iff (rst)
    erasing |=> $stable(fuse));

  assert_lock_late_R6: assert property (@(posedge clk) disable iff (rst)
    erasing |=> $stable(lock));

  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy) |-> $past(!wr_n));

endmodule

bind ppi_prog_ctrl ppi_chk u_chk (
  .clk(clk), .rst(rst), .oe_n(oe_n_i), .wr_n(wr_n_i), .rdy(rdy_o),
  .drv(drv_q), .erasing(erasing), .addr(addr), .fuse(fuse_q), .lock(lock_q)
);

// File: tb/tb_ppi_prog_ctrl.sv
`timescale 1ns/1ps
module tb_ppi_prog_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WR_CYC     = 8;
  localparam int ERASE_CYC  = 1024 + 256 + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe = 1'b0;
  logic [1:0] act = 2'b11;
  logic       bsel = 1'b0;
  logic       wr_n = 1'b1;
  logic       oe_n = 1'b1;
  logic       tb_en = 1'b0;
  logic [7:0] tb_d = 8'h00;
  wire  [7:0] data_io;
  logic       rdy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       smp;

  assign data_io = tb_en ? tb_d : 8'hzz;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppi_prog_ctrl dut (
    .clk(clk), .rst(rst), .strobe_i(strobe), .action_i(act), .bsel_i(bsel),
    .wr_n_i(wr_n), .oe_n_i(oe_n), .data_io(data_io), .rdy_o(rdy)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: pops scoreboard entries and compares against the bus
  initial begin
    forever begin
      @(smp);
      while (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'h0, data_io}, {24'h0, e});
      end
    end
  end

  task automatic load(input logic [1:0] a, input logic b, input logic [7:0] v);
    @(negedge clk);
    act = a; bsel = b; tb_d = v; tb_en = 1'b1; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0; tb_en = 1'b0; act = 2'b11;
  endtask

  task automatic command(input logic [7:0] v);
    load(2'b10, 1'b0, v);
  endtask

  task automatic write_pulse(output int busy);
    @(negedge clk);
    wr_n = 1'b0;
    busy = 0;
    @(negedge clk);
    wr_n = 1'b1;
    while (!rdy && busy < 5000) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic read_expect(input logic b, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bsel = b; tb_en = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    -> smp;
    @(negedge clk);
    oe_n = 1'b1;
  endtask

  task automatic released_expect(input string tag);
    @(negedge clk);
    tb_d = 8'h5A; tb_en = 1'b1; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    exp_q.push_back(8'h5A);
    tag_q.push_back(tag);
    -> smp;
    @(negedge clk);
    oe_n = 1'b1; tb_en = 1'b0;
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    load(2'b00, 1'b1, hi);
    load(2'b00, 1'b0, lo);
  endtask

  task automatic set_data(input logic [7:0] hi, input logic [7:0] lo);
    load(2'b01, 1'b1, hi);
    load(2'b01, 1'b0, lo);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int busy;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    check("R10 ready after reset", {31'h0, rdy}, 32'h1);
    released_expect("R10 undefined command after reset keeps bus released");
    command(8'h04);
    read_expect(1'b0, 8'hD9, "R10 fuse reset value");
    read_expect(1'b1, 8'hFF, "R10 lock reset value");

    // R6/R4 chip erase
    command(8'h80);
    write_pulse(busy);
    check("R4 erase busy length", busy, ERASE_CYC);
    command(8'h02);
    set_addr(8'h00, 8'h12);
    read_expect(1'b0, 8'hFF, "R6 flash low byte erased");
    read_expect(1'b1, 8'hFF, "R6 flash high byte erased");
    command(8'h03);
    set_addr(8'h00, 8'h40);
    read_expect(1'b0, 8'hFF, "R6 eeprom erased");

    // R2/R3/R4 flash writes
    command(8'h10);
    set_addr(8'h00, 8'h12);
    set_data(8'hAB, 8'h34);
    write_pulse(busy);
    check("R4 write busy length", busy, WR_CYC);
    set_addr(8'h00, 8'h13);
    set_data(8'h56, 8'h78);
    write_pulse(busy);
    check("R3 second flash write busy", busy, WR_CYC);

    // R9 flash reads with byte select
    command(8'h02);
    set_addr(8'h00, 8'h12);
    read_expect(1'b0, 8'h34, "R9 flash low byte");
    read_expect(1'b1, 8'hAB, "R2 flash high byte");
    set_addr(8'h00, 8'h13);
    read_expect(1'b0, 8'h78, "R9 second word low");
    read_expect(1'b1, 8'h56, "R2 second word high");

    // R1 action 11 does nothing
    load(2'b11, 1'b0, 8'h12);
    read_expect(1'b0, 8'h78, "R1 idle action leaves address");

    // EEPROM write and read
    command(8'h11);
    set_addr(8'h00, 8'h40);
    set_data(8'h00, 8'hC3);
    write_pulse(busy);
    check("R3 eeprom write busy", busy, WR_CYC);
    command(8'h03);
    read_expect(1'b0, 8'hC3, "R9 eeprom byte");

    // signature
    command(8'h08);
    set_addr(8'h00, 8'h00);
    read_expect(1'b0, 8'h1E, "R9 signature byte 0");
    set_addr(8'h00, 8'h01);
    read_expect(1'b0, 8'h93, "R9 signature byte 1");
    set_addr(8'h00, 8'h02);
    read_expect(1'b0, 8'h05, "R9 signature byte 2");
    set_addr(8'h00, 8'h03);
    read_expect(1'b0, 8'hFF, "R9 signature index 3");

    // R11 fuse and lock writes
    command(8'h40);
    set_data(8'h00, 8'h3C);
    write_pulse(busy);
    command(8'h20);
    set_data(8'h00, 8'hFC);
    write_pulse(busy);
    command(8'h04);
    read_expect(1'b0, 8'h3C, "R11 fuse written");
    read_expect(1'b1, 8'hFC, "R11 lock written");

    // R7 loads and write pulses during busy are ignored
    command(8'h10);
    set_addr(8'h00, 8'h20);
    set_data(8'h22, 8'h11);
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    load(2'b00, 1'b0, 8'h21);
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    while (!rdy) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R7 second pulse during busy ignored", {31'h0, rdy}, 32'h1);
    command(8'h02);
    read_expect(1'b0, 8'h11, "R7 address load during busy ignored");

    // R8 undefined command
    command(8'h55);
    write_pulse(busy);
    check("R8 undefined command stays ready", busy, 0);
    released_expect("R8 undefined command keeps bus released");
    command(8'h04);
    read_expect(1'b0, 8'h3C, "R8 fuse untouched by undefined command");

    // R5 released when output enable high
    command(8'h02);
    @(negedge clk);
    tb_d = 8'hA5; tb_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 bus released with oe high", {24'h0, data_io}, 32'hA5);
    tb_en = 1'b0;

    // R6 second erase: fuse kept, lock restored
    command(8'h80);
    write_pulse(busy);
    check("R6 erase busy length again", busy, ERASE_CYC);
    command(8'h04);
    read_expect(1'b0, 8'h3C, "R6 fuse kept after erase");
    read_expect(1'b1, 8'hFF, "R6 lock restored after erase");
    command(8'h02);
    set_addr(8'h00, 8'h12);
    read_expect(1'b1, 8'hFF, "R6 written word erased");

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule